// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel of a general-purpose timer. A free-running counter, kept outside the block and shared with other channels, supplies its count value, an overflow pulse and a "held" indication (the counter is stopped and kept at zero). The channel works either as an input capture or as an unbuffered output compare/PWM generator. In capture mode it latches the count when a selected edge arrives on its input pin. In compare mode it changes its output level when the count equals the channel register. An optional toggle on counter overflow lets it produce a PWM waveform.

A two-bit edge/level field and a mode bit pick the function. When the field is zero, the channel does not own its pin, which is left to general-purpose I/O. In that state the mode bit sets the output level that the channel will present once a compare mode is enabled. Software reaches the block through a simple write port. Address 0 is the control word and address 1 is the channel register.

Top module: `tim_chan_top`

## Requirements
- R1: After reset the mode bit and edge field are zero, `chanOut` is 1, `chanOutEn` is 0, `chanFlag` is 0 and `chanReg` is 0.
- R2: The control word at address 0 has mode in bit 0, edge field in bits 2:1, overflow-toggle enable in bit 3 and flag-clear in bit 4. With the edge field at 00, a mode bit of 1 drives the internal output level to 0 and a mode bit of 0 drives it to 1, within two cycles of the write, while `chanOutEn` stays 0.
- R3: With a non-zero edge field, a mode bit of 1 selects output compare and sets `chanOutEn` to 1. A mode bit of 0 selects input capture, with `chanOutEn` 0. On entry to compare mode, the preset output level is kept.
- R4: Writes to the mode bit and edge field take effect only while `cntHeld` is 1. At any other time they are ignored, and the channel keeps its function and edge setting.
- R5: In capture mode the edge field selects the active input edge: 01 is rising, 10 is falling, 11 is both. A change of the opposite kind captures nothing and leaves the flag unchanged.
- R6: An active input edge loads `chanReg` with the count present at the clock edge SYNC_STAGES cycles after the pin change, and sets `chanFlag`. No capture occurs while `cntHeld` is 1.
- R7: In compare mode, while the counter runs, a clock edge that sees `cntValue` equal to `chanReg` sets `chanFlag` and applies the edge-field action to `chanOut` at that edge: 01 toggles, 10 clears, 11 sets. While the counter is held, the output does not change.
- R8: In compare mode with overflow-toggle enabled, a `cntOverflow` pulse inverts `chanOut`. With it disabled, the pulse has no effect. A match in the same cycle takes priority over the toggle.
- R9: `chanFlag` is sticky. Writing the control word with bit 4 set clears it, and a set in the same cycle wins over the clear.
- R10: A write to address 1 loads `chanReg` with `wrData` at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 selects control word, 1 selects channel register |
| wrData | input | CNT_W | Write data |
| cntValue | input | CNT_W | Shared counter value |
| cntHeld | input | 1 | Shared counter stopped and held at zero |
| cntOverflow | input | 1 | One-cycle counter overflow pulse |
| chanIn | input | 1 | Pin input for capture (asynchronous) |
| chanOut | output | 1 | Channel output level |
| chanOutEn | output | 1 | Channel drives the pin (compare mode) |
| chanFlag | output | 1 | Sticky capture/match flag |
| chanReg | output | CNT_W | Channel capture/compare register |

## Verification
A wrong mode or edge register appears at once on `chanOutEn`, or on the next match, capture or overflow, as an output action of the wrong kind or a capture on the wrong edge. A slip in synchronizer depth shows as a captured count that is off by the error. A fault in the output state shows on `chanOut` in the cycle after the match that touches it. Flag faults show either as a flag that does not survive an idle stretch, or as a clear that beats a same-cycle set.

// File: rtl/tim_chan_pkg.sv
package tim_chan_pkg;

  // bit positions of the control word written at address 0
  localparam int CTL_MODE    = 0;
  localparam int CTL_EDGE_LO = 1;
  localparam int CTL_OVF     = 3;
  localparam int CTL_FLAGCLR = 4;
  localparam int CTL_W       = 5;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,   // capture rising / toggle on match
    EDGE_FALL = 2'b10,   // capture falling / clear on match
    EDGE_BOTH = 2'b11    // capture either / set on match
  } edgeSel_t;

  typedef struct packed {
    logic capLoad;
    logic swLoad;
    logic outSet;
    logic outClr;
    logic outTog;
    logic flagSet;
    logic flagClr;
  } chanStrobes_t;

endpackage

// File: rtl/tim_chan_ctrl.sv
module tim_chan_ctrl
  import tim_chan_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlWrite,
  input  logic [CTL_W-1:0]   ctlData,
  input  logic               valWrite,
  input  logic               cntHeld,
  input  logic               cntOverflow,
  input  logic               cmpEqual,
  input  logic               chanIn,
  output chanStrobes_t       strobes,
  output logic               compareMode
);

  logic     modeBit;
  edgeSel_t edgeSel;
  logic     ovfTogEn;

  logic [SYNC_STAGES-1:0] syncReg;
  logic                   lastIn;
  logic                   inRise, inFall;
  logic                   running, captureMode;
  logic                   capHit, matchHit, ovfHit;

  // mode/edge only writable while the shared counter is held
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeBit  <= 1'b0;
      edgeSel  <= EDGE_OFF;
      ovfTogEn <= 1'b0;
    end else if (ctlWrite) begin
      ovfTogEn <= ctlData[CTL_OVF];
      if (cntHeld) begin
        modeBit <= ctlData[CTL_MODE];
        edgeSel <= edgeSel_t'(ctlData[CTL_EDGE_LO +: 2]);
      end
    end
  end

  // input synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= chanIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], chanIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastIn <= 1'b0;
    else       lastIn <= syncReg[SYNC_STAGES-1];
  end

  assign inRise = syncReg[SYNC_STAGES-1] & ~lastIn;
  assign inFall = ~syncReg[SYNC_STAGES-1] & lastIn;

  assign running     = ~cntHeld;
  assign compareMode = (edgeSel != EDGE_OFF) && modeBit;
  assign captureMode = (edgeSel != EDGE_OFF) && !modeBit;

  always_comb begin
    unique case (edgeSel)
      EDGE_RISE: capHit = inRise;
      EDGE_FALL: capHit = inFall;
      EDGE_BOTH: capHit = inRise | inFall;
      default:   capHit = 1'b0;
    endcase
    capHit = capHit && captureMode && running;
  end

  assign matchHit = compareMode && running && cmpEqual;
  assign ovfHit   = compareMode && running && ovfTogEn && cntOverflow && !matchHit;

  always_comb begin
    strobes         = '0;
    strobes.capLoad = capHit;
    strobes.swLoad  = valWrite;
    strobes.flagSet = capHit | matchHit;
    strobes.flagClr = ctlWrite && ctlData[CTL_FLAGCLR];
    if (edgeSel == EDGE_OFF) begin
      // preset level: mode 1 -> low, mode 0 -> high
      strobes.outSet = !modeBit;
      strobes.outClr = modeBit;
    end else if (matchHit) begin
      unique case (edgeSel)
        EDGE_RISE: strobes.outTog = 1'b1;
        EDGE_FALL: strobes.outClr = 1'b1;
        default:   strobes.outSet = 1'b1;
      endcase
    end else if (ovfHit) begin
      strobes.outTog = 1'b1;
    end
  end

endmodule

// File: rtl/tim_chan_dp.sv
module tim_chan_dp
  import tim_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobes_t     strobes,
  input  logic [CNT_W-1:0] cntValue,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] chanReg,
  output logic             chanOut,
  output logic             chanFlag,
  output logic             cmpEqual
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                chanReg <= '0;
    else if (strobes.capLoad) chanReg <= cntValue;
    else if (strobes.swLoad)  chanReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               chanOut <= 1'b1;
    else if (strobes.outSet) chanOut <= 1'b1;
    else if (strobes.outClr) chanOut <= 1'b0;
    else if (strobes.outTog) chanOut <= ~chanOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                chanFlag <= 1'b0;
    else if (strobes.flagSet) chanFlag <= 1'b1;
    else if (strobes.flagClr) chanFlag <= 1'b0;
  end

  assign cmpEqual = (cntValue == chanReg);

endmodule

// File: rtl/tim_chan_top.sv
module tim_chan_top
  import tim_chan_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] cntValue,
  input  logic             cntHeld,
  input  logic             cntOverflow,
  input  logic             chanIn,
  output logic             chanOut,
  output logic             chanOutEn,
  output logic             chanFlag,
  output logic [CNT_W-1:0] chanReg
);

  chanStrobes_t strobes;
  logic         cmpEqual;

  tim_chan_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ctlWrite    (wrEn && !wrAddr),
    .ctlData     (wrData[CTL_W-1:0]),
    .valWrite    (wrEn && wrAddr),
    .cntHeld     (cntHeld),
    .cntOverflow (cntOverflow),
    .cmpEqual    (cmpEqual),
    .chanIn      (chanIn),
    .strobes     (strobes),
    .compareMode (chanOutEn)
  );

  tim_chan_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cntValue (cntValue),
    .wrData   (wrData),
    .chanReg  (chanReg),
    .chanOut  (chanOut),
    .chanFlag (chanFlag),
    .cmpEqual (cmpEqual)
  );

endmodule

// File: rtl/tim_chan_chk.sv
module tim_chan_chk
  import tim_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrAddr,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] cntValue,
  input logic             cntHeld,
  input logic             chanOut,
  input logic             chanOutEn,
  input logic             chanFlag,
  input logic [CNT_W-1:0] chanReg,
  input chanStrobes_t     strobes
);

  p_mode_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    !cntHeld |=> $stable(chanOutEn));

  p_match_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (chanOutEn && !cntHeld && cntValue == chanReg) |=> chanFlag);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cntHeld && chanOutEn) |=> $stable(chanOut));

  p_out_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.outSet, strobes.outClr, strobes.outTog}));

  p_capture_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capLoad |=> chanReg == $past(cntValue));

  p_no_capture_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    cntHeld |-> !strobes.capLoad);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (chanFlag && !(wrEn && !wrAddr && wrData[CTL_FLAGCLR])) |=> chanFlag);

endmodule

bind tim_chan_top tim_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .cntValue  (cntValue),
  .cntHeld   (cntHeld),
  .chanOut   (chanOut),
  .chanOutEn (chanOutEn),
  .chanFlag  (chanFlag),
  .chanReg   (chanReg),
  .strobes   (strobes)
);

// File: tb/tim_chan_top_test.sv
module tim_chan_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic             wrAddr = 1'b0;
  logic [CNT_W-1:0] wrData = '0;
  logic [CNT_W-1:0] cnt = '0;
  logic             cntHeld = 1'b1;
  logic             cntOverflow = 1'b0;
  logic             chanIn = 1'b0;
  logic             chanOut, chanOutEn, chanFlag;
  logic [CNT_W-1:0] chanReg;

  int total = 0;
  int bad = 0;
  logic expOut = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tim_chan_top #(.CNT_W(CNT_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntValue(cnt), .cntHeld(cntHeld), .cntOverflow(cntOverflow), .chanIn(chanIn),
    .chanOut(chanOut), .chanOutEn(chanOutEn), .chanFlag(chanFlag), .chanReg(chanReg)
  );

  function automatic logic applyAct(input logic [1:0] f, input logic cur);
    case (f)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  function automatic logic edgeActive(input logic [1:0] f, input logic oldV, input logic newV);
    logic r, fl;
    r  = !oldV && newV;
    fl = oldV && !newV;
    case (f)
      2'b01:   return r;
      2'b10:   return fl;
      2'b11:   return r | fl;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: returns at the falling edge, counter advanced if running
  task automatic step();
    @(negedge clk);
    if (cntHeld) cnt = '0;
    else cnt = cnt + 1'b1;
  endtask

  task automatic wr(input logic a, input logic [CNT_W-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  function automatic logic [CNT_W-1:0] ctlWord(input logic clr, input logic ovf,
                                               input logic [1:0] f, input logic m);
    return {{(CNT_W-5){1'b0}}, clr, ovf, f, m};
  endfunction

  task automatic cmpRun(input logic [1:0] f, input logic ovf, input logic [CNT_W-1:0] cmp);
    cntHeld = 1'b1; step();
    wr(1'b0, ctlWord(1'b1, ovf, f, 1'b1));
    wr(1'b1, cmp);
    check("R3 compare enables pin", chanOutEn, 1);
    check("R3 level kept on entry", chanOut, expOut);
    check("R10 value write", chanReg, cmp);
    cntHeld = 1'b0;
    while (cnt != cmp) step();
    check("R7 no action before match", chanOut, expOut);
    check("R7 flag clear before match", chanFlag, 0);
    step();
    expOut = applyAct(f, expOut);
    check("R7 match action", chanOut, expOut);
    check("R7 match flag", chanFlag, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0]       f;
    logic [CNT_W-1:0] c, prevReg;
    logic             prevFlag, newPin;
    void'($urandom(32'h5eed_0042));

    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    check("R1 out", chanOut, 1);
    check("R1 outEn", chanOutEn, 0);
    check("R1 flag", chanFlag, 0);
    check("R1 reg", chanReg, 0);

    // R2 preset levels with field 00
    wr(1'b0, ctlWord(1'b0, 1'b0, 2'b00, 1'b1));
    step();
    check("R2 preset low", chanOut, 0);
    check("R2 pin released", chanOutEn, 0);
    wr(1'b0, ctlWord(1'b0, 1'b0, 2'b00, 1'b0));
    step();
    check("R2 preset high", chanOut, 1);
    wr(1'b0, ctlWord(1'b0, 1'b0, 2'b00, 1'b1));
    step();
    expOut = 1'b0;
    check("R2 preset low again", chanOut, 0);

    // R3 compare entry keeps preset low; R7 toggle
    cmpRun(2'b01, 1'b0, 16'd4);

    // R4 write while running ignored: still compare, still toggle
    wr(1'b0, ctlWord(1'b1, 1'b0, 2'b10, 1'b0));
    check("R4 function unchanged", chanOutEn, 1);
    check("R9 flag cleared", chanFlag, 0);
    wr(1'b1, cnt + 16'd6);
    check("R10 write while running", chanReg, cnt + 16'd5);
    while (cnt != chanReg) step();
    step();
    expOut = ~expOut;
    check("R4 edge setting unchanged", chanOut, expOut);

    // R7 random compare actions
    for (int i = 0; i < 16; i++) begin
      cmpRun(2'($urandom_range(1, 3)), 1'b0, 16'($urandom_range(2, 40)));
    end

    // R8 PWM: preset high, clear on match, toggle on overflow
    cntHeld = 1'b1; step();
    wr(1'b0, ctlWord(1'b1, 1'b0, 2'b00, 1'b0));
    step();
    expOut = 1'b1;
    check("R2 preset high before pwm", chanOut, 1);
    cmpRun(2'b10, 1'b1, 16'd5);
    repeat (2) step();
    cntOverflow = 1'b1; step(); cntOverflow = 1'b0;
    expOut = ~expOut;
    check("R8 overflow toggle", chanOut, expOut);
    wr(1'b0, ctlWord(1'b0, 1'b0, 2'b10, 1'b1));
    cntOverflow = 1'b1; step(); cntOverflow = 1'b0;
    check("R8 toggle disabled", chanOut, expOut);

    // R8 match wins over overflow: out is 1, set on match
    cntHeld = 1'b1; step();
    wr(1'b0, ctlWord(1'b1, 1'b1, 2'b11, 1'b1));
    wr(1'b1, 16'd4);
    cntHeld = 1'b0;
    while (cnt != 16'd4) step();
    cntOverflow = 1'b1; step(); cntOverflow = 1'b0;
    check("R8 match priority", chanOut, 1);
    expOut = 1'b1;
    wr(1'b0, ctlWord(1'b1, 1'b1, 2'b11, 1'b1));
    check("R9 clear by write", chanFlag, 0);
    step();
    check("R9 stays clear", chanFlag, 0);

    // R9 set wins over clear in the same cycle
    cntHeld = 1'b1; step();
    wr(1'b0, ctlWord(1'b1, 1'b0, 2'b01, 1'b1));
    wr(1'b1, 16'd6);
    cntHeld = 1'b0;
    while (cnt != 16'd6) step();
    wr(1'b0, ctlWord(1'b1, 1'b0, 2'b01, 1'b1));
    expOut = ~expOut;
    check("R9 set beats clear", chanFlag, 1);
    check("R7 toggle at match", chanOut, expOut);
    repeat (5) step();
    check("R9 flag sticky", chanFlag, 1);

    // R5/R6 capture with random pin changes per edge setting
    for (int g = 1; g <= 3; g++) begin
      f = 2'(g);
      cntHeld = 1'b1; step();
      wr(1'b0, ctlWord(1'b1, 1'b0, f, 1'b0));
      wr(1'b1, 16'hAAAA);
      check("R3 capture releases pin", chanOutEn, 0);
      chanIn = ~chanIn;
      repeat (4) step();
      check("R6 no capture while held", chanReg, 16'hAAAA);
      check("R6 no flag while held", chanFlag, 0);
      cntHeld = 1'b0;
      repeat (3) step();
      for (int k = 0; k < 10; k++) begin
        prevReg  = chanReg;
        prevFlag = chanFlag;
        newPin   = (k < 2) ? ~chanIn : 1'($urandom_range(0, 1));
        c        = cnt;
        if (edgeActive(f, chanIn, newPin)) begin
          chanIn = newPin;
          repeat (3) step();
          check("R6 captured count", chanReg, c + 16'd2);
          check("R6 capture flag", chanFlag, 1);
          wr(1'b0, ctlWord(1'b1, 1'b0, f, 1'b0));
        end else begin
          chanIn = newPin;
          repeat (3) step();
          check("R5 inactive edge ignored", chanReg, prevReg);
          check("R5 flag unchanged", chanFlag, prevFlag);
        end
        repeat (2) step();
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule